// File: doc/BRIEF.md
# Serial interrupt frame encoder

This block reports sixteen legacy IRQ levels and four PCI interrupt levels to a host over one shared, open-drain serial interrupt wire that is synchronous to the bus clock. The host frames each packet. A start cycle holds the wire low for several clocks. A fixed run of indication slots follows, one slot per interrupt. A stop cycle closes the packet, and its length tells the devices the next framing mode. The encoder follows this framing from the wire itself. In the slot that belongs to an asserted interrupt, it pulls the wire low.

Each slot is three clocks long: a sample clock, a recovery clock and a turnaround clock. The encoder takes one snapshot of its inputs when the start cycle is recognized, and every slot of that packet reports from this snapshot. The host can leave the wire idle between packets (quiet mode). In that mode the encoder can request a packet itself when its inputs no longer match what it last reported. As a sideband, the four PCI interrupts can be left out of the stream. INTA is then reported in parallel on a dedicated pull-down output.

Top module: `sirq_encoder`

## Requirements
- R1: A start is recognized when the sampled wire has been low for 4 to 8 consecutive clocks and is then sampled high. A low run of 3 or fewer clocks, or of 9 or more, starts no packet, and the encoder then drives nothing.
- R2: The clock after the first high clock of the start is a turnaround clock. Slot k (k = 0..20) has its sample clock 2+3k clocks after that first high clock. The slot order is IRQ0..IRQ15 in slots 0..15, a reserved slot 16 that is never driven, and INTA, INTB, INTC, INTD in slots 17..20. A low wire in a sample clock means the interrupt is asserted.
- R3: When the encoder pulls a sample clock low, it drives the wire high in the following recovery clock. It never drives in a turnaround clock, and it never drives a slot whose interrupt is not asserted.
- R4: The inputs are captured at the clock edge that recognizes the start. Input changes during the slots do not appear until the next packet.
- R5: The encoder reads the length of the stop cycle from the wire. A low run of exactly 2 clocks selects quiet mode, and any other length (normally 3) selects continuous mode. Reset selects continuous mode. Between the stop and the next start, the encoder does not drive the wire.
- R6: In quiet mode, if the encoder is idle, the wire was sampled high, and the inputs differ from the last snapshot, the encoder drives the wire low for exactly 2 clocks, starting in the clock after the edge that sees the difference. If the inputs match the last snapshot, it does not drive.
- R7: In continuous mode the encoder never starts a packet by itself.
- R8: When `pci_parallel` is 1 at the start edge, slots 17..20 are not driven in that packet. `inta_pull` equals `pci_parallel AND pci_req[0]` at all times, with 1 meaning pull INTA low.
- R9: During and right after reset, the serial driver is off (`sirq_oe` = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| irq_req | input | 16 | Legacy IRQ levels, 1 = asserted |
| pci_req | input | 4 | INTA..INTD levels (bit 0 = INTA), 1 = asserted |
| pci_parallel | input | 1 | 1 = leave the PCI interrupts out of the stream and report INTA in parallel |
| sirq_i | input | 1 | Sampled level of the serial interrupt wire |
| sirq_oe | output | 1 | Serial wire driver enable |
| sirq_o | output | 1 | Serial wire value while enabled |
| inta_pull | output | 1 | Parallel INTA pull-down request |

## Verification
The hardest situation to reach is a packet that the encoder requests itself in quiet mode. To get there, a full packet must first end with a stop of exactly two clocks. Then an input has to change while the wire is idle. Finally the host model must notice the encoder's two-clock pull-down and stretch it into a valid start. The bench does these steps in order, and the packet that follows must carry the new input state. The snapshot rule needs a similar setup: the inputs are changed partway through the slots, and the old and the new values are checked in two packets in a row.

// File: rtl/sirq_encoder.sv
module sirq_encoder #(
  parameter int NUM_IRQ    = 16,
  parameter int NUM_PCI    = 4,
  parameter int START_MIN  = 4,
  parameter int START_MAX  = 8,
  parameter int REQ_LEN    = 2,
  parameter int QUIET_STOP = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_PCI-1:0] pci_req,
  input  logic               pci_parallel,
  input  logic               sirq_i,
  output logic               sirq_oe,
  output logic               sirq_o,
  output logic               inta_pull
);
  localparam int NSLOT = NUM_IRQ + 1 + NUM_PCI;
  localparam int SW    = $clog2(NSLOT);
  localparam int CW    = $clog2(START_MAX + 2);
  localparam int RW    = $clog2(REQ_LEN + 1);
  localparam logic [CW-1:0] LMIN  = CW'(START_MIN);
  localparam logic [CW-1:0] LMAX  = CW'(START_MAX);
  localparam logic [CW-1:0] LQST  = CW'(QUIET_STOP);
  localparam logic [CW-1:0] LSAT  = {CW{1'b1}};
  localparam logic [SW-1:0] SLAST = SW'(NSLOT - 1);
  localparam logic [SW-1:0] SRSV  = SW'(NUM_IRQ);
  localparam logic [RW-1:0] RLAST = RW'(REQ_LEN - 1);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_TA, S_SLOT, S_STOP} st_t;

  st_t              st;
  logic [CW-1:0]    low_cnt;
  logic [SW-1:0]    slot;
  logic [1:0]       ph;
  logic [RW-1:0]    rcnt;
  logic [NSLOT-1:0] snap;
  logic             quiet;

  wire [NSLOT-1:0] cur_vec  = {pci_parallel ? {NUM_PCI{1'b0}} : pci_req, 1'b0, irq_req};
  wire             pending  = cur_vec != snap;
  wire             start_ok = sirq_i && (low_cnt >= LMIN) && (low_cnt <= LMAX);
  wire             bit_on   = snap[slot];
  wire             drv_lo   = (st == S_REQ) || (st == S_SLOT && ph == 2'd0 && bit_on);
  wire             drv_hi   = (st == S_SLOT) && (ph == 2'd1) && bit_on;

  assign sirq_oe   = drv_lo | drv_hi;
  assign sirq_o    = drv_hi;
  assign inta_pull = pci_parallel & pci_req[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      low_cnt <= '0;
    else if (sirq_i)
      low_cnt <= '0;
    else if (low_cnt != LSAT)
      low_cnt <= low_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      slot  <= '0;
      ph    <= '0;
      rcnt  <= '0;
      snap  <= '0;
      quiet <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (start_ok) begin
            snap <= cur_vec;
            st   <= S_TA;
          end else if (quiet && sirq_i && pending) begin
            rcnt <= '0;
            st   <= S_REQ;
          end
        end
        S_REQ: begin
          rcnt <= rcnt + 1'b1;
          if (rcnt == RLAST) st <= S_IDLE;
        end
        S_TA: begin
          slot <= '0;
          ph   <= '0;
          st   <= S_SLOT;
        end
        S_SLOT: begin
          if (ph == 2'd2) begin
            ph <= '0;
            if (slot == SLAST) st <= S_STOP;
            else slot <= slot + 1'b1;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        S_STOP: begin
          if (sirq_i && low_cnt != '0) begin
            quiet <= (low_cnt == LQST);
            st    <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3
  rec_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SLOT && sirq_oe && !sirq_o) |=> (sirq_oe && sirq_o));
  // R3
  ta_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sirq_oe && sirq_o) |=> !sirq_oe);
  // R4
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SLOT) |=> $stable(snap));
  // R2
  rsv_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SLOT && slot == SRSV) |-> !sirq_oe);
  // R6
  busy_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !sirq_i) |=> (st != S_REQ));
  // R6
  req_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && $past(st) != S_REQ) |=> (st == S_REQ) |=> (st == S_REQ));
  // R7
  cont_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!quiet && st != S_REQ) |=> (st != S_REQ));
endmodule

// File: tb/sim_sirq_encoder.sv
module sim_sirq_encoder;
  localparam int CLK_P = 10;
  localparam int NS    = 21;
  localparam int NV    = 6;
  // {irq, pci, parallel, start length}
  localparam logic [24:0] VEC [NV] = '{
    {16'h0000, 4'h0, 1'b0, 4'd6},
    {16'h8421, 4'h5, 1'b0, 4'd4},
    {16'hFFFF, 4'hF, 1'b0, 4'd8},
    {16'h0001, 4'h8, 1'b0, 4'd5},
    {16'h1234, 4'hF, 1'b1, 4'd7},
    {16'hA5A5, 4'h1, 1'b1, 4'd6}
  };

  logic        clk = 0, rst_n = 0;
  logic [15:0] irq_req = '0;
  logic [3:0]  pci_req = '0;
  logic        pci_parallel = 0, host_pull = 0;
  logic        sirq_oe, sirq_o, inta_pull;
  wire         line = !(host_pull || (sirq_oe && !sirq_o));
  int          nchk = 0, nfail = 0;
  bit          done = 0;

  always #(CLK_P/2) clk = ~clk;

  sirq_encoder u0 (.clk(clk), .rst_n(rst_n), .irq_req(irq_req), .pci_req(pci_req),
    .pci_parallel(pci_parallel), .sirq_i(line), .sirq_oe(sirq_oe), .sirq_o(sirq_o),
    .inta_pull(inta_pull));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_start(input int n);
    for (int i = 0; i < n; i++) begin
      host_pull = 1;
      @(negedge clk);
    end
    host_pull = 0;
  endtask

  task automatic collect(output logic [NS-1:0] got, output bit shape);
    shape = 1;
    @(negedge clk); #1 if (sirq_oe) shape = 0;
    for (int k = 0; k < NS; k++) begin
      @(negedge clk); #1 got[k] = !line;
      @(negedge clk); #1
      if (got[k] && !(sirq_oe && sirq_o)) shape = 0;
      if (!got[k] && sirq_oe) shape = 0;
      @(negedge clk); #1 if (sirq_oe) shape = 0;
    end
  endtask

  task automatic host_stop(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk); host_pull = 1;
    end
    @(negedge clk); host_pull = 0;
    @(negedge clk);
  endtask

  function automatic logic [NS-1:0] expect_vec(input logic [15:0] i, input logic [3:0] p, input logic par);
    return {par ? 4'h0 : p, 1'b0, i};
  endfunction

  task automatic quiet_watch(input int n, input string req);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1 if (sirq_oe) seen = 1;
    end
    chk(!seen, req, {31'd0, seen}, 32'd0);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [NS-1:0] got;
    bit shape;
    // R9 reset state
    #(CLK_P * 2 + 1);
    chk(!sirq_oe, "R9 oe in reset", {31'd0, sirq_oe}, 32'd0);
    @(negedge clk); rst_n = 1;
    @(negedge clk); #1 chk(!sirq_oe, "R9 oe after reset", {31'd0, sirq_oe}, 32'd0);

    // R1 R2 R3 R8 vector table, continuous stop
    foreach (VEC[v]) begin
      @(negedge clk);
      irq_req = VEC[v][24:9]; pci_req = VEC[v][8:5]; pci_parallel = VEC[v][4];
      #1 chk(inta_pull == (VEC[v][4] & VEC[v][5]), "R8 inta_pull", {31'd0, inta_pull},
             {31'd0, VEC[v][4] & VEC[v][5]});
      host_start(int'(VEC[v][3:0]));
      collect(got, shape);
      chk(got == expect_vec(VEC[v][24:9], VEC[v][8:5], VEC[v][4]), "R2 R1 R8 slot data",
          {11'd0, got}, {11'd0, expect_vec(VEC[v][24:9], VEC[v][8:5], VEC[v][4])});
      chk(shape, "R3 recovery/turnaround", {31'd0, shape}, 32'd1);
      host_stop(3);
    end
    pci_parallel = 0;

    // R1 short and long start runs ignored
    irq_req = 16'hFFFF; pci_req = 4'hF;
    @(negedge clk); host_start(3); collect(got, shape);
    chk(got == '0 && shape, "R1 low run 3 ignored", {11'd0, got}, 32'd0);
    @(negedge clk); host_start(9); collect(got, shape);
    chk(got == '0 && shape, "R1 low run 9 ignored", {11'd0, got}, 32'd0);

    // R4 snapshot held across input change
    @(negedge clk); irq_req = 16'h00F0; pci_req = 4'h2;
    host_start(6);
    fork
      collect(got, shape);
      begin repeat (12) @(negedge clk); irq_req = 16'h0F00; pci_req = 4'h4; end
    join
    chk(got == expect_vec(16'h00F0, 4'h2, 1'b0), "R4 snapshot old", {11'd0, got},
        {11'd0, expect_vec(16'h00F0, 4'h2, 1'b0)});
    host_stop(3);
    @(negedge clk); host_start(6); collect(got, shape);
    chk(got == expect_vec(16'h0F00, 4'h4, 1'b0), "R4 snapshot new", {11'd0, got},
        {11'd0, expect_vec(16'h0F00, 4'h4, 1'b0)});
    host_stop(3);

    // R7 continuous mode: no self start on change
    @(negedge clk); irq_req = 16'h0003;
    quiet_watch(10, "R7 no self start");

    // R5 stop of 2 selects quiet; R6 no drive when unchanged
    @(negedge clk); host_start(6); collect(got, shape);
    chk(got == expect_vec(16'h0003, 4'h4, 1'b0), "R5 packet before quiet", {11'd0, got},
        {11'd0, expect_vec(16'h0003, 4'h4, 1'b0)});
    host_stop(2);
    quiet_watch(8, "R6 no request without change");

    // R6 self start after change
    @(negedge clk); irq_req = 16'h8000;
    @(negedge clk); #1
    chk(sirq_oe && !sirq_o, "R6 request drive low", {30'd0, sirq_oe, sirq_o}, 32'd2);
    host_start(6); collect(got, shape);
    chk(got == expect_vec(16'h8000, 4'h4, 1'b0), "R6 requested packet", {11'd0, got},
        {11'd0, expect_vec(16'h8000, 4'h4, 1'b0)});
    chk(shape, "R3 shape in requested packet", {31'd0, shape}, 32'd1);

    // R5 stop of 3 returns to continuous mode
    host_stop(3);
    @(negedge clk); irq_req = 16'h0010;
    quiet_watch(10, "R5 continuous after stop 3");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule